// File: doc/BRIEF.md
# J1850 In-Frame Response Transmit Sequencer

This block decides when and how a J1850 byte data link controller sends an in-frame response (IFR) after the main body of a received message. The host loads response bytes into a one-entry holding register and chooses one of three request modes. The first mode sends one byte with no CRC. The second sends several bytes and appends a CRC. The third sends several bytes with no CRC. The block waits for the end-of-data (EOD) symbol that closes the main frame and then starts the response. It follows the rules of the chosen mode for retries, aborts and self-clearing.

On its lower side the block hands symbols to a bit/symbol layer as a valid/ready stream. It learns from that layer when a byte has finished, when arbitration is lost, when a bus or receive error occurs, and when another node's IFR byte is received. Host bytes enter as a second valid/ready stream. `hd_ready` is high exactly while the holding register is empty, so a host that stalls simply keeps `hd_valid` high. On the symbol side `tx_valid` stays high with stable `tx_data` and `tx_kind` until the layer raises `tx_ready`. The symbol layer may hold `tx_ready` low for any number of cycles. Request bits, the end command, the status-clear write and the frame events are plain single-cycle pulses.

Top module: `j1850_ifr_tx`

## Requirements
- R1: With request bit 0 (single byte) armed and a byte held, an `ev_eod` pulse makes `tx_valid` rise on the next cycle with `tx_kind`=1 (byte preceded by a normalization bit) and the held byte. After `ev_tx_done`, no CRC byte and no EOD symbol (`tx_kind`=2) follow, and the request is cleared, so a later `ev_eod` sends nothing.
- R2: If a single-byte response gets `ev_arb_lost`, nothing is offered until the next `ev_tx_done`, which marks the end of the winning byte. The same byte is then offered again with `tx_kind`=0 (no normalization bit). This repeats until the byte completes, `end_cmd` is pulsed while waiting, or a bus error occurs.
- R3: A request only counts for an `ev_eod` if it was written in an earlier cycle. A request written in the same cycle as `ev_eod` sends nothing then and fires on the next `ev_eod`.
- R4: An armed single-byte request is dropped by `ev_ifr_rx` (another node's IFR byte received) or by `ev_rx_err`. The held byte is kept.
- R5: In the multi-byte modes (bit 1 = with CRC, bit 2 = without CRC), the first byte has `tx_kind`=1 and later bytes have `tx_kind`=0, in load order. `tde_req` is high while such a response is running, the holding register is empty and `end_cmd` has not yet been given.
- R6: After `end_cmd`, once the last byte's `ev_tx_done` arrives, the with-CRC mode sends a `tx_kind`=0 byte followed by a `tx_kind`=2 EOD symbol. That byte is the one's complement of the CRC-8 over the IFR bytes only, with polynomial 0x1D, initial value 0xFF, most significant bit first. The without-CRC mode sends only the EOD symbol.
- R7: `ev_bus_err` while a request is armed or active clears it, sets `sts_bus_err`, and leaves `tx_valid` low on the next cycle.
- R8: `ev_arb_lost` during a multi-byte response stops it at once with no retry and sets `sts_arb_lost`.
- R9: If a response byte completes, the holding register is empty and `end_cmd` was not given, or if the armed EOD arrives with nothing held, the response stops and `sts_underrun` is set.
- R10: When several request bits are written together, bit 0 wins over bit 1, and bit 1 wins over bit 2. Request writes made while a response is being sent are ignored.
- R11: `sts_underrun` (clear bit 0), `sts_arb_lost` (clear bit 1) and `sts_bus_err` (clear bit 2) are sticky. A `sts_clr_wr` pulse clears only the flags whose clear bit is 1, and a set in the same cycle wins over a clear.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_kind` hold their values.
- R13: `hd_ready` is high exactly when the holding register is empty. A byte is taken when `hd_valid` and `hd_ready` are both high.
- R14: After reset, `tx_valid` and `tde_req` are low, all status flags are low and `hd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_valid | input | 1 | Host byte valid |
| hd_ready | output | 1 | Holding register empty |
| hd_data | input | DW | Host response byte |
| req_wr | input | 1 | Request write strobe |
| req_bits | input | 3 | Bit 0 single byte, bit 1 multi-byte with CRC, bit 2 multi-byte without CRC |
| end_cmd | input | 1 | End-of-data command pulse |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Write-one-to-clear mask for the status flags |
| ev_eod | input | 1 | EOD symbol of the main frame detected |
| ev_tx_done | input | 1 | Byte on the bus finished (own byte or winning byte) |
| ev_arb_lost | input | 1 | Arbitration lost on the current byte |
| ev_bus_err | input | 1 | Bus error detected |
| ev_ifr_rx | input | 1 | IFR byte from another node received |
| ev_rx_err | input | 1 | Receive error |
| tx_valid | output | 1 | Symbol offered to the symbol layer |
| tx_ready | input | 1 | Symbol layer accepts the symbol |
| tx_kind | output | 2 | 0 byte, 1 byte with normalization bit, 2 EOD symbol |
| tx_data | output | DW | Byte to send |
| tde_req | output | 1 | Next response byte wanted |
| sts_underrun | output | 1 | Sticky transmit underrun flag |
| sts_arb_lost | output | 1 | Sticky multi-byte arbitration loss flag |
| sts_bus_err | output | 1 | Sticky bus error flag |

## Verification
The bench targets the corner cases below and the failure each would show. A request written in the very cycle of the EOD pulse is one: a design that samples the live request would send too early. A single-byte retry after lost arbitration is another: a design that kept the normalization bit, or did not wait for the winning byte, would offer the wrong kind or offer it too soon. For multi-byte responses it checks underrun, lost arbitration, the CRC value and the closing EOD. A design that retried, skipped the complement, seeded the CRC wrongly or forgot the EOD would show up there. It also checks priority among request bits written together and writes made during a response, which a careless design would let through and re-arm. Back-pressure on the symbol stream and selective write-one-to-clear of each flag are exercised as well.

// File: rtl/j1850_ifr_pkg.sv
package j1850_ifr_pkg;
  localparam int NREQ = 3;
  localparam int NSTS = 3;

  typedef enum logic [1:0] {
    K_BYTE    = 2'd0,
    K_BYTE_NB = 2'd1,
    K_EOD     = 2'd2
  } txk_e;

  typedef enum logic [1:0] {
    M_NONE, M_SINGLE, M_CRC, M_NOCRC
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_SEND, S_WAIT, S_RETRY, S_SCRC, S_WCRC, S_SEOD
  } st_e;
endpackage

// File: rtl/j1850_ifr_hold.sv
module j1850_ifr_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  AST_HOLD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready)); // R13
endmodule

// File: rtl/j1850_ifr_crc.sv
module j1850_ifr_crc #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, nxt;

  always_comb begin
    nxt = (start ? SEED : crc_q) ^ din;
    for (int b = 0; b < W; b++)
      nxt = nxt[W-1] ? ((nxt << 1) ^ POLY) : (nxt << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= SEED;
    else if (upd) crc_q <= nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/j1850_ifr_status.sv
module j1850_ifr_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                f_q <= 1'b0;
      else if (set[i])           f_q <= 1'b1;
      else if (clr_wr && clr[i]) f_q <= 1'b0;
    end
    assign flags[i] = f_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (f_q && !(clr_wr && clr[i])) |=> f_q); // R11
  end
endmodule

// File: rtl/j1850_ifr_tx.sv
module j1850_ifr_tx
  import j1850_ifr_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CRC_POLY = 8'h1D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_valid,
  output logic          hd_ready,
  input  logic [DW-1:0] hd_data,
  input  logic          req_wr,
  input  logic [NREQ-1:0] req_bits,
  input  logic          end_cmd,
  input  logic          sts_clr_wr,
  input  logic [NSTS-1:0] sts_clr,
  input  logic          ev_eod,
  input  logic          ev_tx_done,
  input  logic          ev_arb_lost,
  input  logic          ev_bus_err,
  input  logic          ev_ifr_rx,
  input  logic          ev_rx_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    tx_kind,
  output logic [DW-1:0] tx_data,
  output logic          tde_req,
  output logic          sts_underrun,
  output logic          sts_arb_lost,
  output logic          sts_bus_err
);
  st_e           st_q, st_n;
  mode_e         mode_q, mode_n, req_mode;
  logic          first_q, first_n, last_q, last_n;
  logic [DW-1:0] cur_q, cur_n;
  logic          take, crc_start;
  logic          set_ud, set_arb, set_err;
  logic          hold_v;
  logic [DW-1:0] hold_d, crc;
  logic [NSTS-1:0] flags;
  logic          is_multi;
  txk_e          kind_c;

  j1850_ifr_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(hd_valid), .in_ready(hd_ready),
    .in_data(hd_data), .take(take), .out_valid(hold_v), .out_data(hold_d));

  j1850_ifr_crc #(.W(DW), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .upd(take),
    .din(hold_d), .crc(crc));

  j1850_ifr_status #(.N(NSTS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set({set_err, set_arb, set_ud}),
    .clr_wr(sts_clr_wr), .clr(sts_clr), .flags(flags));

  assign sts_underrun = flags[0];
  assign sts_arb_lost = flags[1];
  assign sts_bus_err  = flags[2];

  // fixed priority among the request bits: single, then with CRC, then without
  always_comb begin
    if (req_bits[0])      req_mode = M_SINGLE;
    else if (req_bits[1]) req_mode = M_CRC;
    else if (req_bits[2]) req_mode = M_NOCRC;
    else                  req_mode = M_NONE;
  end

  assign is_multi = (mode_q == M_CRC) || (mode_q == M_NOCRC);

  always_comb begin
    st_n = st_q; mode_n = mode_q; first_n = first_q; cur_n = cur_q;
    last_n = (st_q == S_IDLE) ? 1'b0 : (last_q || end_cmd);
    take = 1'b0; crc_start = 1'b0;
    set_ud = 1'b0; set_arb = 1'b0; set_err = 1'b0;
    if (st_q != S_IDLE && st_q != S_ARMED && ev_bus_err) begin
      set_err = 1'b1; st_n = S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_wr) begin
          mode_n = req_mode;
          st_n   = (req_mode == M_NONE) ? S_IDLE : S_ARMED;
        end
        S_ARMED: begin
          if (ev_bus_err) begin
            set_err = 1'b1; st_n = S_IDLE;
          end else if (ev_eod) begin
            if (hold_v) begin
              take = 1'b1; crc_start = 1'b1; cur_n = hold_d;
              first_n = 1'b1; st_n = S_SEND;
            end else begin
              set_ud = 1'b1; st_n = S_IDLE;
            end
          end else if (mode_q == M_SINGLE && (ev_ifr_rx || ev_rx_err)) begin
            st_n = S_IDLE;
          end else if (req_wr) begin
            mode_n = req_mode;
            if (req_mode == M_NONE) st_n = S_IDLE;
          end
        end
        S_SEND: if (tx_ready) st_n = S_WAIT;
        S_WAIT: begin
          if (ev_arb_lost) begin
            if (is_multi) begin
              set_arb = 1'b1; st_n = S_IDLE;
            end else begin
              st_n = S_RETRY;
            end
          end else if (ev_tx_done) begin
            if (!is_multi) begin
              st_n = S_IDLE;
            end else if (hold_v) begin
              take = 1'b1; cur_n = hold_d; first_n = 1'b0; st_n = S_SEND;
            end else if (last_q || end_cmd) begin
              st_n = (mode_q == M_CRC) ? S_SCRC : S_SEOD;
            end else begin
              set_ud = 1'b1; st_n = S_IDLE;
            end
          end
        end
        S_RETRY: begin
          if (end_cmd) st_n = S_IDLE;
          else if (ev_tx_done) begin
            first_n = 1'b0; st_n = S_SEND;
          end
        end
        S_SCRC: if (tx_ready) st_n = S_WCRC;
        S_WCRC: begin
          if (ev_arb_lost) begin
            set_arb = 1'b1; st_n = S_IDLE;
          end else if (ev_tx_done) begin
            st_n = S_SEOD;
          end
        end
        S_SEOD: if (tx_ready) st_n = S_IDLE;
        default: st_n = S_IDLE;
      endcase
    end
    if (st_n == S_IDLE) begin
      mode_n = M_NONE; last_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; mode_q <= M_NONE; first_q <= 1'b0;
      last_q <= 1'b0; cur_q <= '0;
    end else begin
      st_q <= st_n; mode_q <= mode_n; first_q <= first_n;
      last_q <= last_n; cur_q <= cur_n;
    end
  end

  always_comb begin
    tx_valid = 1'b0; kind_c = K_BYTE; tx_data = '0;
    unique case (st_q)
      S_SEND: begin
        tx_valid = 1'b1; kind_c = first_q ? K_BYTE_NB : K_BYTE; tx_data = cur_q;
      end
      S_SCRC: begin
        tx_valid = 1'b1; tx_data = ~crc;
      end
      S_SEOD: begin
        tx_valid = 1'b1; kind_c = K_EOD;
      end
      default: ;
    endcase
  end
  assign tx_kind = kind_c;

  assign tde_req = is_multi && (st_q == S_SEND || st_q == S_WAIT) && !hold_v && !last_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ev_bus_err) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_kind))); // R12

  AST_BUSERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> !tx_valid); // R7

  AST_MULTI_ARB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && is_multi && ev_arb_lost && !ev_bus_err) |=>
      (sts_arb_lost && !tx_valid)); // R8

  AST_SINGLE_NO_EOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SINGLE) |-> !(tx_valid && tx_kind == 2'd2)); // R1
endmodule

// File: tb/j1850_ifr_tx_tb.sv
module j1850_ifr_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hd_valid, hd_ready;
  logic [7:0] hd_data;
  logic       req_wr;
  logic [2:0] req_bits;
  logic       end_cmd, sts_clr_wr;
  logic [2:0] sts_clr;
  logic       ev_eod, ev_tx_done, ev_arb_lost, ev_bus_err, ev_ifr_rx, ev_rx_err;
  logic       tx_valid, tx_ready;
  logic [1:0] tx_kind;
  logic [7:0] tx_data;
  logic       tde_req, sts_underrun, sts_arb_lost, sts_bus_err;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  j1850_ifr_tx u_dut (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_ready(hd_ready),
    .hd_data(hd_data), .req_wr(req_wr), .req_bits(req_bits), .end_cmd(end_cmd),
    .sts_clr_wr(sts_clr_wr), .sts_clr(sts_clr), .ev_eod(ev_eod),
    .ev_tx_done(ev_tx_done), .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
    .ev_ifr_rx(ev_ifr_rx), .ev_rx_err(ev_rx_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_data(tx_data), .tde_req(tde_req),
    .sts_underrun(sts_underrun), .sts_arb_lost(sts_arb_lost), .sts_bus_err(sts_bus_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] b[8], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ b[i];
      for (int k = 0; k < 8; k++) c = c[7] ? {c[6:0], 1'b0} ^ 8'h1D : {c[6:0], 1'b0};
    end
    return ~c;
  endfunction

  task automatic p_eod();  ev_eod = 1;      @(negedge clk); ev_eod = 0;      endtask
  task automatic p_done(); ev_tx_done = 1;  @(negedge clk); ev_tx_done = 0;  endtask
  task automatic p_arb();  ev_arb_lost = 1; @(negedge clk); ev_arb_lost = 0; endtask
  task automatic p_berr(); ev_bus_err = 1;  @(negedge clk); ev_bus_err = 0;  endtask
  task automatic p_ifr();  ev_ifr_rx = 1;   @(negedge clk); ev_ifr_rx = 0;   endtask
  task automatic p_rxe();  ev_rx_err = 1;   @(negedge clk); ev_rx_err = 0;   endtask
  task automatic p_end();  end_cmd = 1;     @(negedge clk); end_cmd = 0;     endtask

  task automatic load(input logic [7:0] b);
    hd_data = b; hd_valid = 1; @(negedge clk); hd_valid = 0;
  endtask
  task automatic request(input logic [2:0] b);
    req_bits = b; req_wr = 1; @(negedge clk); req_wr = 0;
  endtask
  task automatic clear(input logic [2:0] m);
    sts_clr = m; sts_clr_wr = 1; @(negedge clk); sts_clr_wr = 0;
  endtask

  task automatic get_tx(output logic [1:0] k, output logic [7:0] d, output bit got);
    got = 0; k = 0; d = 0;
    for (int w = 0; w < 20 && !got; w++) begin
      if (tx_valid && tx_ready) begin
        k = tx_kind; d = tx_data; got = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int w = 0; w < n; w++) begin
      chk(tx_valid == 0, tag, tx_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    logic [1:0] k; logic [7:0] d; bit g;
    request(3'b001); p_eod(); get_tx(k, d, g); p_done();
  endtask

  task automatic run_multi(input logic [2:0] bits, input bit use_crc, input int n);
    logic [7:0] b[8];
    logic [1:0] k; logic [7:0] d; bit g;
    for (int i = 0; i < 8; i++) b[i] = 8'($urandom);
    load(b[0]); request(bits); p_eod();
    for (int i = 0; i < n; i++) begin
      get_tx(k, d, g);
      chk(g && k == ((i == 0) ? 2'd1 : 2'd0) && d == b[i], "R5 byte", {k, d}, {((i == 0) ? 2'd1 : 2'd0), b[i]});
      if (i == 0) chk(tde_req == 1, "R5 tde", tde_req, 1);
      if (i < n - 1) load(b[i + 1]); else p_end();
      p_done();
    end
    if (use_crc) begin
      get_tx(k, d, g);
      chk(g && k == 0 && d == crc_ref(b, n), "R6 crc", {k, d}, {2'd0, crc_ref(b, n)});
      p_done();
    end
    get_tx(k, d, g);
    chk(g && k == 2, "R6 eod", k, 2);
    chk(tde_req == 0, "R5 tde end", tde_req, 0);
    quiet(2, "R6 after");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] k; logic [7:0] d; bit g; int seed;
    seed = $urandom(32'h1850);
    rst_n = 0; hd_valid = 0; hd_data = 0; req_wr = 0; req_bits = 0; end_cmd = 0;
    sts_clr_wr = 0; sts_clr = 0; ev_eod = 0; ev_tx_done = 0; ev_arb_lost = 0;
    ev_bus_err = 0; ev_ifr_rx = 0; ev_rx_err = 0; tx_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    // R14 reset state
    chk(tx_valid == 0 && tde_req == 0, "R14 outputs", {tx_valid, tde_req}, 0);
    chk({sts_underrun, sts_arb_lost, sts_bus_err} == 0, "R14 flags",
        {sts_underrun, sts_arb_lost, sts_bus_err}, 0);
    chk(hd_ready == 1, "R14 hd_ready", hd_ready, 1);

    // R1 single byte
    load(8'hA5);
    chk(hd_ready == 0, "R13 full", hd_ready, 0);
    request(3'b001); p_eod();
    chk(tx_valid == 1 && tx_kind == 1 && tx_data == 8'hA5, "R1 first offer",
        {tx_valid, tx_kind, tx_data}, {1'b1, 2'd1, 8'hA5});
    get_tx(k, d, g); p_done();
    quiet(3, "R1 no tail");
    p_eod(); quiet(3, "R1 cleared");

    // R2 retry without normalization bit, then abort by end command
    load(8'h5A); request(3'b001); p_eod(); get_tx(k, d, g);
    p_arb(); quiet(3, "R2 wait winner");
    p_done();
    get_tx(k, d, g);
    chk(g && k == 0 && d == 8'h5A, "R2 retry", {k, d}, {2'd0, 8'h5A});
    p_arb(); p_end(); p_done(); quiet(3, "R2 abort");

    // R3 request written in the EOD cycle
    load(8'h3C);
    req_bits = 3'b001; req_wr = 1; ev_eod = 1; @(negedge clk); req_wr = 0; ev_eod = 0;
    chk(tx_valid == 0, "R3 late", tx_valid, 0);
    quiet(2, "R3 late");
    p_eod();
    chk(tx_valid == 1 && tx_kind == 1 && tx_data == 8'h3C, "R3 next eod",
        {tx_valid, tx_kind, tx_data}, {1'b1, 2'd1, 8'h3C});
    get_tx(k, d, g); p_done();

    // R4 pending single dropped by foreign IFR or receive error
    load(8'h66); request(3'b001); p_ifr(); p_eod(); quiet(3, "R4 ifr_rx");
    request(3'b001); p_rxe(); p_eod(); quiet(3, "R4 rx_err");
    chk(hd_ready == 0, "R4 byte kept", hd_ready, 1'b0);
    drain();
    chk(hd_ready == 1, "R13 drained", hd_ready, 1);

    // R7 bus error while armed
    load(8'h12); request(3'b010); p_berr();
    chk(sts_bus_err == 1, "R7 flag", sts_bus_err, 1);
    p_eod(); quiet(3, "R7 cleared");
    clear(3'b100);
    chk(sts_bus_err == 0, "R11 w1c err", sts_bus_err, 0);
    drain();

    // R9 underrun, R11 selective clear
    load(8'h11); request(3'b100); p_eod(); get_tx(k, d, g);
    chk(tde_req == 1, "R5 tde", tde_req, 1);
    p_done();
    chk(sts_underrun == 1, "R9 flag", sts_underrun, 1);
    quiet(3, "R9 halt");
    clear(3'b110);
    chk(sts_underrun == 1, "R11 other bits", sts_underrun, 1);
    clear(3'b001);
    chk(sts_underrun == 0, "R11 w1c ud", sts_underrun, 0);
    request(3'b010); p_eod();
    chk(sts_underrun == 1, "R9 empty at eod", sts_underrun, 1);
    clear(3'b001);

    // R8 arbitration loss in multi-byte mode
    load(8'h22); request(3'b010); p_eod(); get_tx(k, d, g); load(8'h33); p_arb();
    chk(sts_arb_lost == 1, "R8 flag", sts_arb_lost, 1);
    p_done(); quiet(4, "R8 halt");
    clear(3'b010); drain();

    // R10 priority and ignored writes
    load(8'h44); request(3'b111); p_eod(); get_tx(k, d, g);
    chk(g && k == 1 && tde_req == 0, "R10 single wins", {k, tde_req}, {2'd1, 1'b0});
    p_done(); quiet(3, "R10 single wins");
    run_multi(3'b110, 1'b1, 3);
    load(8'h55); request(3'b100); p_eod(); get_tx(k, d, g);
    request(3'b001); p_end(); p_done(); get_tx(k, d, g);
    chk(g && k == 2, "R10 no crc", k, 2);
    load(8'h67); p_eod(); quiet(3, "R10 ignored");
    drain();

    // R12 back-pressure
    load(8'h77); request(3'b001); tx_ready = 0; p_eod();
    for (int w = 0; w < 3; w++) begin
      chk(tx_valid == 1 && tx_kind == 1 && tx_data == 8'h77, "R12 hold",
          {tx_valid, tx_kind, tx_data}, {1'b1, 2'd1, 8'h77});
      @(negedge clk);
    end
    tx_ready = 1; get_tx(k, d, g);
    chk(g && d == 8'h77, "R12 accept", d, 8'h77);
    p_done();

    // R5 R6 random multi-byte responses
    for (int it = 0; it < 20; it++) begin
      bit c = 1'($urandom);
      run_multi(c ? 3'b010 : 3'b100, c, 1 + int'($urandom % 5));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule